// File: doc/BRIEF.md
# Oversampling Majority-Vote Serial Receiver

This block receives asynchronous serial bytes in the 8N1 format: one low start bit, eight data bits sent least significant bit first, and one high stop bit. The serial line first passes through a synchronizer. A falling edge on the synchronized line, seen while the receiver is idle, starts a frame. A tick divider then produces sixteen sub-sample ticks per bit period. The divider period comes from a table indexed by a 3-bit rate select.

Within each bit, only the six central sub-samples count toward that bit's value. The edges of the bit period are ignored. A small counter per bit holds the number of high samples, and the counter's top bit gives the bit value. The start bit is judged as soon as its window closes. If too many of its samples are high, the receiver treats the edge as a glitch and drops back to idle.

At the end of the stop bit, the receiver loads the eight decided data bits into the output register and raises a one-cycle completion pulse. If a new start edge arrives in that same cycle, the receiver accepts it, so frames sent back to back with no gap are all received.

Top module: `uart_os_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `rx_byte` reads 0x00 and `rx_valid` is low until a frame completes. A reset asserted in the middle of a frame abandons that frame.
- R2: The sub-sample tick period in clocks is CLK_HZ / (16 × rate), where rate is 9600, 19200, 38400, 57600 or 115200 for `baud_sel` codes 0 to 4. Codes 5, 6 and 7 select 9600.
- R3: A frame is 160 sub-sample ticks long: start bit, eight data bits and stop bit, with data least significant bit first. When the frame completes, `rx_byte` takes the received byte and `rx_valid` is high for exactly one clock.
- R4: Only sub-samples 6 to 11 of each bit are counted. Any line activity in sub-samples 0 to 5 and 12 to 15 of a data bit has no effect on the byte.
- R5: Each bit has a 3-bit count of high central samples, ranging from 0 to 6. The bit reads 1 when the count is 4 or more. A count of 3 or less, including an even split of 3 high and 3 low, reads 0.
- R6: When the start bit's count of high central samples exceeds 2, the frame is abandoned with no pulse, and `rx_byte` keeps its previous value. A start bit with 2 or fewer high samples is accepted.
- R7: `rx_byte` changes only in the cycle in which `rx_valid` is high, and holds its value between frames.
- R8: Falling edges that occur during a frame do not restart it. All per-bit counts are cleared when a frame starts, so the outcome of one frame does not depend on the frame before it.
- R9: A falling edge detected in the cycle a frame completes starts the next frame. Back-to-back frames with no idle time are each delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_sel | input | 3 | Rate select code indexing the tick divider table |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Most recently received byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |

## Verification
Completing a frame and detecting the next start edge can happen in the same clock. This occurs when a transmitter running at exactly the receiver's rate begins a new start bit right after a stop bit: the last stop-bit tick and the new falling edge, both delayed by the same synchronizer, reach the control logic together. The bench provokes this by driving two frames with no idle slot between them. It judges the result by requiring two separate completion pulses, each carrying its own byte in order. A receiver that misses the second start, or that carries stale counts into the second frame, shows a missing pulse or a wrong second byte.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;

  localparam int unsigned SUBS_PER_BIT  = 16;
  localparam int unsigned FRAME_BITS    = 10;
  localparam int unsigned DATA_BITS     = 8;
  localparam int unsigned WIN_FIRST     = 6;
  localparam int unsigned WIN_LAST      = 11;
  localparam int unsigned START_MAX_HI  = 2;
  localparam int unsigned VOTE_W        = 3;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned SEL_CODES     = 8;
  localparam int unsigned FRAME_SUBS    = SUBS_PER_BIT * FRAME_BITS;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // Line rate for a select code; unlisted codes fall back to the slowest rate.
  function automatic int unsigned rate_for_code(input int unsigned code);
    case (code)
      1:       return 19200;
      2:       return 38400;
      3:       return 57600;
      4:       return 115200;
      default: return 9600;
    endcase
  endfunction

  // Divider terminal count: clocks per sub-sample tick minus one.
  function automatic int unsigned tc_for_code(input int unsigned clk_hz,
                                              input int unsigned code);
    int unsigned q;
    q = clk_hz / (SUBS_PER_BIT * rate_for_code(code));
    return (q == 0) ? 0 : q - 1;
  endfunction

endpackage

// File: rtl/uart_os_sync.sv
module uart_os_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line = chain_q[STAGES-1];
  assign fall = prev_q & ~line;

endmodule

// File: rtl/uart_os_tick.sv
module uart_os_tick
  import uart_os_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned TC_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  input  logic             restart,
  output logic             tick
);

  // The slowest code (0) carries the largest terminal count.
  localparam logic [TC_W-1:0] TC_MAX = TC_W'(tc_for_code(CLK_HZ, 0));

  logic [TC_W-1:0] tc_tab [SEL_CODES];
  logic [TC_W-1:0] tc;
  logic [TC_W-1:0] div_q, div_d;

  for (genvar k = 0; k < SEL_CODES; k++) begin : g_tab
    assign tc_tab[k] = TC_W'(tc_for_code(CLK_HZ, k));
  end

  assign tc   = tc_tab[sel];
  assign tick = run && (div_q >= tc);

  always_comb begin
    div_d = div_q;
    if (restart) begin
      div_d = '0;
    end else if (run) begin
      div_d = tick ? '0 : div_q + TC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= TC_MAX);

endmodule

// File: rtl/uart_os_votes.sv
module uart_os_votes
  import uart_os_pkg::*;
#(
  parameter int unsigned NACC  = 9,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic [CNT_W-1:0]  pos,
  input  logic              din,
  output logic [NACC-2:0]   data_vals,
  output logic [VOTE_W-1:0] start_count
);

  localparam int unsigned SUB_W = $clog2(SUBS_PER_BIT);
  localparam int unsigned BIT_W = CNT_W - SUB_W;

  logic [SUB_W-1:0]  sub;
  logic [BIT_W-1:0]  bit_idx;
  logic              in_win;
  logic [VOTE_W-1:0] acc_q [NACC];
  logic [VOTE_W-1:0] acc_d [NACC];

  assign sub     = pos[SUB_W-1:0];
  assign bit_idx = pos[CNT_W-1:SUB_W];
  assign in_win  = (sub >= SUB_W'(WIN_FIRST)) && (sub <= SUB_W'(WIN_LAST));

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_comb begin
      acc_d[g] = acc_q[g];
      if (clear) begin
        acc_d[g] = '0;
      end else if (tick && in_win && din && (bit_idx == BIT_W'(g))) begin
        acc_d[g] = acc_q[g] + VOTE_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[g] <= '0;
      else        acc_q[g] <= acc_d[g];
    end

    assert_acc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q[g] <= VOTE_W'(WIN_LAST - WIN_FIRST + 1));
  end

  for (genvar d = 0; d < NACC - 1; d++) begin : g_out
    assign data_vals[d] = acc_q[d+1][VOTE_W-1];
  end

  assign start_count = acc_q[0];

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] baud_sel,
  input  logic       rxd,
  output logic [7:0] rx_byte,
  output logic       rx_valid
);

  localparam int unsigned CNT_W   = $clog2(FRAME_SUBS);
  localparam int unsigned NACC    = DATA_BITS + 1;
  localparam int unsigned TC_BITS = $clog2(tc_for_code(CLK_HZ, 0) + 1);
  localparam int unsigned TC_W    = (TC_BITS < 1) ? 1 : TC_BITS;
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_SUBS - 1);
  localparam logic [CNT_W-1:0] JUDGE_POS = CNT_W'(WIN_LAST + 1);

  logic                 line, fall, tick;
  logic [DATA_BITS-1:0] data_vals;
  logic [VOTE_W-1:0]    start_count;

  rx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     pos_q, pos_d;
  logic [7:0]           byte_q, byte_d;
  logic                 valid_q, valid_d;
  logic                 busy, step, last_tick, abort, start;

  uart_os_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (rxd),
    .line(line),
    .fall(fall)
  );

  uart_os_tick #(.CLK_HZ(CLK_HZ), .TC_W(TC_W)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (baud_sel),
    .run    (busy),
    .restart(start),
    .tick   (tick)
  );

  uart_os_votes #(.NACC(NACC), .CNT_W(CNT_W)) i_votes (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .tick       (step),
    .pos        (pos_q),
    .din        (line),
    .data_vals  (data_vals),
    .start_count(start_count)
  );

  assign busy      = (state_q == RX_BUSY);
  assign step      = busy && tick;
  assign last_tick = step && (pos_q == LAST_POS);
  assign abort     = step && (pos_q == JUDGE_POS)
                     && (start_count > VOTE_W'(START_MAX_HI));
  assign start     = fall && (!busy || last_tick);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    if (start) begin
      state_d = RX_BUSY;
      pos_d   = '0;
    end else if (last_tick || abort) begin
      state_d = RX_IDLE;
      pos_d   = '0;
    end else if (step) begin
      pos_d   = pos_q + CNT_W'(1);
    end
  end

  always_comb begin
    byte_d  = byte_q;
    valid_d = last_tick;
    if (last_tick) byte_d = data_vals;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      pos_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      byte_q  <= byte_d;
      valid_q <= valid_d;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_valid = valid_q;

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < CNT_W'(FRAME_SUBS));

  assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));

  assert_abort_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(state_q == RX_BUSY) && !rx_valid) |-> ($past(pos_q) == JUDGE_POS));

endmodule

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;

  localparam int unsigned CLK_HZ = 1_843_200;

  typedef struct packed {
    logic [2:0] sel;
    logic [7:0] data;
    logic [2:0] noise;
  } vec_t;

  // noise: 0 clean, 1 edges of data bits flipped, 2 two central slots flipped,
  // 3 three central slots of bit 0 flipped, 4 four central slots of bit 0 flipped
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hA5, 3'd0}, '{3'd1, 8'h3C, 3'd0}, '{3'd3, 8'hFF, 3'd0},
    '{3'd2, 8'h00, 3'd0}, '{3'd4, 8'h81, 3'd0}, '{3'd5, 8'h5A, 3'd0},
    '{3'd7, 8'hC3, 3'd0}, '{3'd0, 8'h96, 3'd1}, '{3'd2, 8'h69, 3'd2},
    '{3'd0, 8'hB7, 3'd3}, '{3'd1, 8'h24, 3'd3}, '{3'd0, 8'h4E, 3'd4},
    '{3'd4, 8'hD2, 3'd1}
  };

  logic       clk, rst_n, rxd;
  logic [2:0] baud_sel;
  logic [7:0] rx_byte;
  logic       rx_valid;

  int n_vec, n_bad, pulses;
  logic [7:0] got, got_prev;
  logic       prev_valid, finished;

  uart_os_rx #(.CLK_HZ(CLK_HZ)) i_uart_os_rx (
    .clk(clk), .rst_n(rst_n), .baud_sel(baud_sel), .rxd(rxd),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int slot_clocks(input logic [2:0] sel);
    int rate;
    case (sel)
      3'd1: rate = 19200;
      3'd2: rate = 38400;
      3'd3: rate = 57600;
      3'd4: rate = 115200;
      default: rate = 9600;
    endcase
    return CLK_HZ / (16 * rate);
  endfunction

  function automatic logic slot_level(input logic [7:0] d, input logic [2:0] nz, input int idx);
    int b = idx / 16;
    int s = idx % 16;
    logic base, inv;
    inv = 1'b0;
    if (b == 0) base = 1'b0;
    else if (b == 9) base = 1'b1;
    else base = d[b-1];
    if (b >= 1 && b <= 8) begin
      case (nz)
        3'd1: inv = (s <= 6) || (s >= 13);
        3'd2: inv = (s == 8) || (s == 10);
        3'd3: inv = (b == 1) && (s >= 8) && (s <= 10);
        3'd4: inv = (b == 1) && (s >= 8) && (s <= 11);
        default: inv = 1'b0;
      endcase
    end
    return base ^ inv;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] d, input logic [2:0] nz);
    if (nz == 3'd3) return d & 8'hFE;
    if (nz == 3'd4) return d ^ 8'h01;
    return d;
  endfunction

  // Pulse monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      chk(!prev_valid, "R3 pulse width", 2, 1);
      pulses   = pulses + 1;
      got_prev = got;
      got      = rx_byte;
    end
    prev_valid = rst_n && rx_valid;
  end

  task automatic send(input logic [2:0] sel, input logic [7:0] d, input logic [2:0] nz);
    int p = slot_clocks(sel);
    baud_sel = sel;
    for (int i = 0; i < 160; i++) begin
      rxd = slot_level(d, nz, i);
      repeat (p) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic idle(input logic [2:0] sel);
    repeat (16 * slot_clocks(sel) + 20) @(negedge clk);
  endtask

  task automatic start_glitch(input int low_slots, input logic [2:0] sel);
    int p = slot_clocks(sel);
    baud_sel = sel;
    rxd = 1'b0;
    repeat (low_slots * p) @(negedge clk);
    rxd = 1'b1;
    repeat (176 * p + 20) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int p0;
    logic [7:0] hold;
    n_vec = 0; n_bad = 0; pulses = 0; got = '0; got_prev = '0;
    prev_valid = 1'b0; finished = 1'b0;
    rst_n = 1'b0; rxd = 1'b1; baud_sel = 3'd0;
    repeat (5) @(negedge clk);
    chk(rx_byte == 8'h00, "R1 reset byte", rx_byte, 0);
    chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(rx_valid == 1'b0 && pulses == 0, "R1 idle after reset", pulses, 0);

    // Vector table: R2 rates, R3 framing, R4 ignored edges, R5 majority, R8 clearing
    for (int v = 0; v < NV; v++) begin
      p0 = pulses;
      send(VECS[v].sel, VECS[v].data, VECS[v].noise);
      idle(VECS[v].sel);
      chk(pulses == p0 + 1, "R2/R3 one pulse per frame", pulses - p0, 1);
      chk(got == exp_byte(VECS[v].data, VECS[v].noise), "R3/R4/R5/R8 byte",
          got, exp_byte(VECS[v].data, VECS[v].noise));
    end

    // R7: byte holds with line idle
    hold = rx_byte;
    p0 = pulses;
    repeat (400) @(negedge clk);
    chk(rx_byte == hold && pulses == p0, "R7 hold", rx_byte, hold);

    // R6: start with 4 and 3 high central samples rejected, 2 accepted
    p0 = pulses;
    start_glitch(9, 3'd0);
    chk(pulses == p0 && rx_byte == hold, "R6 reject 4 high", pulses - p0, 0);
    start_glitch(10, 3'd0);
    chk(pulses == p0 && rx_byte == hold, "R6 reject 3 high", pulses - p0, 0);
    start_glitch(11, 3'd0);
    chk(pulses == p0 + 1, "R6 accept 2 high pulse", pulses - p0, 1);
    chk(got == 8'hFF, "R6 accept 2 high byte", got, 8'hFF);

    // R9: back-to-back frames, completion and next start in one cycle
    p0 = pulses;
    send(3'd1, 8'h5C, 3'd0);
    send(3'd1, 8'hE1, 3'd0);
    idle(3'd1);
    chk(pulses == p0 + 2, "R9 two pulses", pulses - p0, 2);
    chk(got_prev == 8'h5C, "R9 first byte", got_prev, 8'h5C);
    chk(got == 8'hE1, "R9 second byte", got, 8'hE1);

    // R1: reset in mid-frame
    baud_sel = 3'd0;
    rxd = 1'b0;
    repeat (40 * slot_clocks(3'd0)) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_byte == 8'h00 && rx_valid == 1'b0, "R1 mid-frame reset", rx_byte, 0);
    rxd = 1'b1;
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    p0 = pulses;
    send(3'd0, 8'h3A, 3'd0);
    idle(3'd0);
    chk(pulses == p0 + 1 && got == 8'h3A, "R1 recovery frame", got, 8'h3A);

    finish_run();
  end

endmodule